// File: doc/BRIEF.md
# Dual Auxiliary PWM Generator

This block drives two auxiliary pulse-width-modulated outputs. Both share one period and one free-running period counter. The counter advances once per prescaler tick. With the default divide ratio of one, a period is 256 clock cycles, which is 48.8 kHz from a 12.5 MHz clock. Each channel holds an 8-bit duty value. Its output is high while the shared counter is below that value, so both outputs rise together at the start of every period. Typical uses are auxiliary switching stages, or a crude DAC once an external low-pass filter follows the pin.

Software writes duty values through a one-bit channel address, an 8-bit data bus and a write strobe, and can read them back through a separate read address. A write takes effect on the next cycle. No shadow copy waits for the period boundary. A one-cycle period-start pulse marks each counter wrap.

Top module: `aux_pwm_dual`

## Requirements
- R1: With the default divide ratio, the period counter advances by one each clock and wraps from 255 to 0, so one period lasts 256 clock cycles.
- R2: A channel output is high exactly while the counter is below its duty value, giving `duty` high cycles per period (0 to 255 of 256).
- R3: Both outputs rise in the same cycle, the first cycle of a period (counter 0), whenever both duty values are non-zero.
- R4: A duty write is visible on the output in the cycle after the write strobe. A new value not above the current count drives the output low at once, a larger value drives it high at once, and the full new duty shows from the next period.
- R5: After reset both duty values read as 0 and both outputs are low.
- R6: A duty of 0 keeps the output low for every cycle, including across the counter wrap.
- R7: `period_start_o` is high for exactly one cycle per period, in the first cycle in which the counter is 0 after a wrap.
- R8: `rd_data_o` returns the duty value of the channel selected by `rd_addr_i` (0 selects channel 0, 1 selects channel 1). A write to one channel leaves the other channel's value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Duty write strobe |
| wr_addr_i | input | 1 | Channel selected for the write |
| wr_data_i | input | 8 | Duty value to write |
| rd_addr_i | input | 1 | Channel selected for readback |
| rd_data_o | output | 8 | Duty value of the selected channel |
| pwm_o | output | 2 | PWM outputs, bit n is channel n |
| period_start_o | output | 1 | One-cycle pulse after each counter wrap |

## Verification
The counter, the duty registers and the period-start flag are all registers. The outputs and the readback are combinational from them, so every result is due in the cycle after the clock edge that captured the stimulus. The bench drives inputs on the falling edge and samples on the next falling edge, which is one rising edge later. It checks each cycle against a counter and a duty copy of its own, and these follow the same rising edges. Period-dependent checks first align to the falling edge where `period_start_o` is seen high, which is the cycle with counter value 0.

// File: rtl/aux_pwm_pkg.sv
package aux_pwm_pkg;
  localparam int unsigned AUX_NUM_CH = 2;
  localparam int unsigned AUX_CNT_W  = 8;
  localparam int unsigned AUX_DIV    = 1;

  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/aux_pwm_prescaler.sv
module aux_pwm_prescaler #(
  parameter int unsigned DIV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_bypass
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [DW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     div_q <= '0;
        else if (div_q == DW'(DIV - 1))  div_q <= '0;
        else                             div_q <= div_q + 1'b1;
      end
      assign tick_o = (div_q == DW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/aux_pwm_counter.sv
module aux_pwm_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             start_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             start_q;
  logic             wrap;

  assign wrap = tick_i && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else begin
      if (tick_i) cnt_q <= cnt_q + 1'b1;
      start_q <= wrap;
    end
  end

  assign cnt_o   = cnt_q;
  assign start_o = start_q;
endmodule

// File: rtl/aux_pwm_chan.sv
module aux_pwm_chan #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] duty_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] duty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   duty_q <= '0;
    else if (we_i) duty_q <= wdata_i;
  end

  // unbuffered compare: a new duty acts in the very next cycle
  assign pwm_o  = (cnt_i < duty_q);
  assign duty_o = duty_q;
endmodule

// File: rtl/aux_pwm_dual.sv
module aux_pwm_dual
  import aux_pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = AUX_NUM_CH,
  parameter int unsigned CNT_W  = AUX_CNT_W,
  parameter int unsigned DIV    = AUX_DIV,
  localparam int unsigned AW    = idx_w(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic [NUM_CH-1:0] pwm_o,
  output logic              period_start_o
);
  logic                    tick;
  logic [CNT_W-1:0]        cnt_q;
  logic [CNT_W-1:0]        duty_arr [NUM_CH];
  logic [NUM_CH*CNT_W-1:0] duty_flat;

  aux_pwm_prescaler #(.DIV(DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  aux_pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .cnt_o  (cnt_q),
    .start_o(period_start_o)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      aux_pwm_chan #(.CNT_W(CNT_W)) u_ch (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (wr_en_i && (wr_addr_i == AW'(i))),
        .wdata_i(wr_data_i),
        .cnt_i  (cnt_q),
        .duty_o (duty_arr[i]),
        .pwm_o  (pwm_o[i])
      );
      assign duty_flat[i*CNT_W +: CNT_W] = duty_arr[i];
    end
  endgenerate

  assign rd_data_o = duty_arr[rd_addr_i];
endmodule

// File: rtl/aux_pwm_dual_chk.sv
module aux_pwm_dual_chk #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned AW     = 1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    wr_en_i,
  input logic [AW-1:0]           wr_addr_i,
  input logic [CNT_W-1:0]        wr_data_i,
  input logic [NUM_CH-1:0]       pwm_o,
  input logic                    period_start_o,
  input logic                    tick_i,
  input logic [CNT_W-1:0]        cnt_i,
  input logic [NUM_CH*CNT_W-1:0] duty_i
);
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i != '1) |=> cnt_i == CNT_W'($past(cnt_i) + 1'b1)); // R1

  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == '1) |=> (cnt_i == '0) && period_start_o); // R7

  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_o |=> !period_start_o); // R7

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    AST_ZERO_DUTY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (duty_i[i*CNT_W +: CNT_W] == '0) |-> !pwm_o[i]); // R6

    AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == AW'(i)) |=> duty_i[i*CNT_W +: CNT_W] == $past(wr_data_i)); // R4

    AST_RISE_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(pwm_o[i]) && !$past(wr_en_i)) |-> cnt_i == '0); // R3
  end
endmodule

bind aux_pwm_dual aux_pwm_dual_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .AW(AW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_addr_i     (wr_addr_i),
  .wr_data_i     (wr_data_i),
  .pwm_o         (pwm_o),
  .period_start_o(period_start_o),
  .tick_i        (tick),
  .cnt_i         (cnt_q),
  .duty_i        (duty_flat)
);

// File: tb/sim_aux_pwm_dual.sv
module sim_aux_pwm_dual;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic [1:0] pwm;
  logic       pstart;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] m_cnt;
  logic [7:0] m_duty [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_pwm_dual u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .pwm_o(pwm), .period_start_o(pstart)
  );

  // bench-side period counter
  always @(posedge clk or negedge rst_n)
    if (!rst_n) m_cnt <= '0;
    else        m_cnt <= m_cnt + 8'd1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit ch, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = ch; wr_data = d;
    @(posedge clk);
    m_duty[ch] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_start();
    do @(negedge clk); while (!pstart);
  endtask

  // per-cycle comparison against the bench model
  task automatic cmp_cycles(input int n, input string req);
    int bad = 0;
    logic [1:0] exp_v = '0, act_v = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int c = 0; c < 2; c++) exp_v[c] = (m_cnt < m_duty[c]);
      if (pwm !== exp_v) begin
        if (bad == 0) act_v = pwm;
        bad++;
      end
    end
    check(bad == 0, req, int'(act_v), int'(exp_v));
  endtask

  task automatic t_reset();
    rd_addr = 1'b0; #1;
    check(rd_data == 8'd0, "R5 duty0", rd_data, 0);
    rd_addr = 1'b1; #1;
    check(rd_data == 8'd0, "R5 duty1", rd_data, 0);
    check(pwm == 2'b00, "R5 outputs", pwm, 0);
  endtask

  task automatic t_period();
    int n = 0;
    wait_start();
    check(m_cnt == 8'd0, "R7 start at count 0", m_cnt, 0);
    do begin @(negedge clk); n++; end while (!pstart);
    check(n == 256, "R1 period length", n, 256);
    n = 0;
    for (int k = 0; k < 512; k++) begin @(negedge clk); if (pstart) n++; end
    check(n == 2, "R7 pulses per 512 cycles", n, 2);
  endtask

  task automatic t_duty(input logic [7:0] d0, input logic [7:0] d1);
    int h0 = 0, h1 = 0;
    wr(1'b0, d0); wr(1'b1, d1);
    wait_start();
    for (int k = 0; k < 256; k++) begin
      if (pwm[0]) h0++;
      if (pwm[1]) h1++;
      @(negedge clk);
    end
    check(h0 == d0, "R2 ch0 high cycles", h0, d0);
    check(h1 == d1, "R2 ch1 high cycles", h1, d1);
    cmp_cycles(256, "R2 per-cycle compare");
  endtask

  task automatic t_align();
    wr(1'b0, 8'd37); wr(1'b1, 8'd200);
    wait_start();
    check(pwm == 2'b11, "R3 both high at period start", pwm, 3);
    repeat (255) @(negedge clk);
    check(pwm == 2'b00, "R3 both low at count 255", pwm, 0);
  endtask

  task automatic t_immediate();
    int h = 0;
    wr(1'b0, 8'd200);
    wait_start();
    repeat (150) @(negedge clk);
    wr(1'b0, 8'd50);
    check(pwm[0] == 1'b0, "R4 drop low at once", pwm[0], 0);
    cmp_cycles(40, "R4 after lowering");
    wait_start();
    for (int k = 0; k < 256; k++) begin if (pwm[0]) h++; @(negedge clk); end
    check(h == 50, "R4 next period duty", h, 50);
    wr(1'b0, 8'd10);
    wait_start();
    repeat (100) @(negedge clk);
    wr(1'b0, 8'd180);
    check(pwm[0] == 1'b1, "R4 raise high at once", pwm[0], 1);
    cmp_cycles(300, "R4 after raising");
  endtask

  task automatic t_zero();
    int h = 0;
    wr(1'b1, 8'd0); wr(1'b0, 8'd255);
    for (int k = 0; k < 600; k++) begin @(negedge clk); if (pwm[1]) h++; end
    check(h == 0, "R6 zero duty never high", h, 0);
  endtask

  task automatic t_readback();
    wr(1'b0, 8'h5A); wr(1'b1, 8'hC3);
    rd_addr = 1'b0; #1;
    check(rd_data == 8'h5A, "R8 read ch0", rd_data, 8'h5A);
    rd_addr = 1'b1; #1;
    check(rd_data == 8'hC3, "R8 read ch1", rd_data, 8'hC3);
    @(negedge clk);
    wr(1'b1, 8'h11);
    rd_addr = 1'b0; #1;
    check(rd_data == 8'h5A, "R8 ch0 untouched by ch1 write", rd_data, 8'h5A);
    rd_addr = 1'b1; #1;
    check(rd_data == 8'h11, "R8 ch1 updated", rd_data, 8'h11);
  endtask

  initial begin
    m_duty[0] = '0; m_duty[1] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_period();
    t_duty(8'd1, 8'd255);
    t_duty(8'd128, 8'd64);
    t_align();
    t_immediate();
    t_zero();
    t_readback();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule